// File: doc/BRIEF.md
# Configuration Bus Range Bridge

The bridge connects one configuration-bus initiator to a set of target regions. On the initiator side it accepts a request level, a direction flag, an address and write data. It returns a one-cycle completion pulse and a byte of read data. Each accepted request is captured into a register stage. The bridge then re-issues it to the downstream side from that stage. The registered address, write data and direction stay constant for as long as the request is outstanding.

Every region is a power-of-two window, aligned to its own size. A region is described by a base and a count of low address bits that are ignored in the match. The registered address selects at most one region, and that region alone sees its request line raised. When regions overlap, the one with the lowest index takes the access. The bridge waits for the selected region's ready, then completes towards the initiator and latches read data for reads. An address outside every window does not hang: it completes at once with zero read data and raises no region request.

The initiator holds its request until it sees the completion pulse, then drops it.

Top module: `cfg_range_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ini_trdy`, `tgt_irdy`, `dn_addr`, `dn_wdata`, `dn_write` and `ini_rdata` all become zero.
- R2: `dn_addr`, `dn_wdata` and `dn_write` load the initiator's address, write data and direction at an edge where `ini_irdy` is high and no downstream request is outstanding. They stay unchanged while a request is outstanding.
- R3: A downstream request raises exactly one bit of `tgt_irdy`, bit i for the lowest i whose range matches. Range i matches when `dn_addr >> RANGE_BITS[i]` equals `RANGE_BASE[i] >> RANGE_BITS[i]`, with the fields packed as `RANGE_BASE[i*ADDR_W +: ADDR_W]` and `RANGE_BITS[i*8 +: 8]`. The bit stays the same throughout the request.
- R4: A request to a mapped region stays raised until that region's `tgt_trdy` bit is high. It drops at the following edge, so it is high for W+1 cycles when the region holds ready low for W cycles.
- R5: `ini_trdy` is a registered one-cycle pulse. It rises at the edge after the request and the selected ready are both high, so it arrives 2+W clock edges after `ini_irdy` is first sampled.
- R6: An address that matches no range raises no `tgt_irdy` bit. It completes with `ini_trdy` two edges after the request is sampled, and with `ini_rdata` equal to zero.
- R7: On a read completion, `ini_rdata` takes the selected region's `tgt_rdata` byte, `tgt_rdata[i*DATA_W +: DATA_W]`. A write leaves `ini_rdata` unchanged.
- R8: No new request starts at the edge that ends the completion cycle, even when `ini_irdy` is still high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ini_irdy | input | 1 | Initiator request, held until completion |
| ini_write | input | 1 | 1 = write, 0 = read |
| ini_addr | input | ADDR_W | Initiator address |
| ini_wdata | input | DATA_W | Initiator write data |
| ini_trdy | output | 1 | One-cycle completion pulse |
| ini_rdata | output | DATA_W | Read data for the last read |
| dn_addr | output | ADDR_W | Registered address to the regions |
| dn_wdata | output | DATA_W | Registered write data to the regions |
| dn_write | output | 1 | Registered direction to the regions |
| tgt_irdy | output | N_RANGE | Per-region request |
| tgt_trdy | input | N_RANGE | Per-region ready |
| tgt_rdata | input | N_RANGE*DATA_W | Per-region read data, packed by index |

## Verification
The assertions check these properties on every cycle:
- the completion is a single-cycle pulse;
- a request is held until its ready arrives;
- no request is re-issued straight after completion;
- the downstream fields and the region selection are frozen while a request is pending;
- a miss completes on the next edge;
- a write never disturbs the read data.

Other properties only the bench's scenarios can show. These are the choice of region for each address, the exact latency for each region's wait, the read-data values and the reset state. The bench sweeps every value of the upper address byte and probes both edges of every window, alternating reads and writes.

// File: rtl/cfgbr_pkg.sv
// Package: shared helpers for the configuration bus range bridge.
// Assumes address widths of at most 32 bits.
package cfgbr_pkg;

    // Width of each packed "ignored low bits" field in the range list.
    localparam int CB_LOWBITS_W = 8;

    // True when addr falls inside the window of size 2**low_bits at base.
    function automatic logic range_hit(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input int unsigned low_bits);
        logic [31:0] keep;
        keep = (low_bits >= 32) ? 32'h0 : ~((32'h1 << low_bits) - 32'h1);
        return (addr & keep) == (base & keep);
    endfunction

endpackage

// File: rtl/cfgbr_req_stage.sv
// Module: cfgbr_req_stage
// Captures an initiator request and keeps the downstream request flag.
// Generates the registered one-cycle completion pulse.
// Assumes the initiator holds ini_irdy until it sees ini_trdy.
module cfgbr_req_stage #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ini_irdy,
    input  logic              ini_write,
    input  logic [ADDR_W-1:0] ini_addr,
    input  logic [DATA_W-1:0] ini_wdata,
    input  logic              tgt_rdy,
    output logic              req_q,
    output logic              ini_trdy,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic              dn_write
);

    // Request flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            ini_trdy <= 1'b0;
        end else begin
            req_q    <= req_q ? !tgt_rdy : (ini_irdy & !ini_trdy);
            ini_trdy <= req_q & tgt_rdy;
        end
    end

    // Capture the request fields whenever nothing is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_addr  <= '0;
            dn_wdata <= '0;
            dn_write <= 1'b0;
        end else if (ini_irdy && !req_q) begin
            dn_addr  <= ini_addr;
            dn_wdata <= ini_wdata;
            dn_write <= ini_write;
        end
    end

    assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> ($stable(dn_addr) && $stable(dn_wdata) && $stable(dn_write)));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !tgt_rdy) |=> req_q);

    assert_trdy_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ini_trdy |=> !ini_trdy);

    assert_no_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ini_trdy |=> !req_q);

endmodule

// File: rtl/cfgbr_range_decode.sv
// Module: cfgbr_range_decode
// Matches the registered address against the range list.
// Routes the request to the lowest-index matching region and selects its
// ready and read data. A miss reports ready with zero data.
// Assumes each base is aligned to its window size.
module cfgbr_range_decode
    import cfgbr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int N_RANGE = 3,
    parameter logic [N_RANGE*ADDR_W-1:0]       RANGE_BASE = '0,
    parameter logic [N_RANGE*CB_LOWBITS_W-1:0] RANGE_BITS = '0
) (
    input  logic                      req,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N_RANGE-1:0]        tgt_trdy,
    input  logic [N_RANGE*DATA_W-1:0] tgt_rdata,
    output logic [N_RANGE-1:0]        tgt_irdy,
    output logic                      sel_rdy,
    output logic [DATA_W-1:0]         sel_rdata,
    output logic                      any_hit
);

    logic [N_RANGE-1:0] hit;
    logic [N_RANGE-1:0] pick;

    // One comparator per range.
    for (genvar g = 0; g < N_RANGE; g++) begin : g_cmp
        assign hit[g] = range_hit(32'(addr),
                                  32'(RANGE_BASE[g*ADDR_W +: ADDR_W]),
                                  int'(RANGE_BITS[g*CB_LOWBITS_W +: CB_LOWBITS_W]));
    end

    // Priority pick: the lowest matching index wins.
    always_comb begin
        pick    = '0;
        any_hit = 1'b0;
        for (int i = 0; i < N_RANGE; i++) begin
            if (hit[i] && !any_hit) begin
                pick[i] = 1'b1;
                any_hit = 1'b1;
            end
        end
    end

    // Completion and data mux; a miss completes with zero data.
    always_comb begin
        sel_rdata = '0;
        sel_rdy   = !any_hit;
        for (int i = 0; i < N_RANGE; i++) begin
            if (pick[i]) begin
                sel_rdata = sel_rdata | tgt_rdata[i*DATA_W +: DATA_W];
                sel_rdy   = sel_rdy | tgt_trdy[i];
            end
        end
    end

    // Request fan-out to the picked region only.
    assign tgt_irdy = pick & {N_RANGE{req}};

endmodule

// File: rtl/cfgbr_rd_capture.sv
// Module: cfgbr_rd_capture
// Holds the initiator read data, updated only on a read completion.
module cfgbr_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] ini_rdata
);

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n)    ini_rdata <= '0;
        else if (load) ini_rdata <= din;
    end

endmodule

// File: rtl/cfg_range_bridge.sv
// Module: cfg_range_bridge (top)
// Configuration bus bridge from one initiator to N_RANGE address windows.
// Each request is registered, re-issued downstream and completed with a
// one-cycle pulse. Assumes non-overlapping, size-aligned windows; on
// overlap the lowest index wins.
module cfg_range_bridge
    import cfgbr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int N_RANGE = 3,
    parameter logic [N_RANGE*ADDR_W-1:0]       RANGE_BASE = {16'h8000, 16'h1000, 16'h0000},
    parameter logic [N_RANGE*CB_LOWBITS_W-1:0] RANGE_BITS = {8'd12, 8'd4, 8'd8}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ini_irdy,
    input  logic                      ini_write,
    input  logic [ADDR_W-1:0]         ini_addr,
    input  logic [DATA_W-1:0]         ini_wdata,
    output logic                      ini_trdy,
    output logic [DATA_W-1:0]         ini_rdata,
    output logic [ADDR_W-1:0]         dn_addr,
    output logic [DATA_W-1:0]         dn_wdata,
    output logic                      dn_write,
    output logic [N_RANGE-1:0]        tgt_irdy,
    input  logic [N_RANGE-1:0]        tgt_trdy,
    input  logic [N_RANGE*DATA_W-1:0] tgt_rdata
);

    logic              req;
    logic              sel_rdy;
    logic              any_hit;
    logic [DATA_W-1:0] sel_rdata;
    logic              rd_load;

    cfgbr_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n), .ini_irdy(ini_irdy), .ini_write(ini_write),
        .ini_addr(ini_addr), .ini_wdata(ini_wdata), .tgt_rdy(sel_rdy),
        .req_q(req), .ini_trdy(ini_trdy), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_write(dn_write)
    );

    cfgbr_range_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RANGE(N_RANGE),
        .RANGE_BASE(RANGE_BASE), .RANGE_BITS(RANGE_BITS)
    ) u_dec (
        .req(req), .addr(dn_addr), .tgt_trdy(tgt_trdy), .tgt_rdata(tgt_rdata),
        .tgt_irdy(tgt_irdy), .sel_rdy(sel_rdy), .sel_rdata(sel_rdata),
        .any_hit(any_hit)
    );

    // Latch read data only when a read request meets its ready.
    assign rd_load = req & sel_rdy & !dn_write;

    cfgbr_rd_capture #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .din(sel_rdata),
        .ini_rdata(ini_rdata)
    );

    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_irdy));

    assert_sel_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !sel_rdy) |=> $stable(tgt_irdy));

    assert_miss_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !any_hit) |=> (ini_trdy && tgt_irdy == '0));

    assert_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && dn_write) |=> $stable(ini_rdata));

endmodule

// File: tb/cfg_range_bridge_tb.sv
module cfg_range_bridge_tb;

    localparam int NR = 3;
    localparam logic [15:0] TB_BASE [NR] = '{16'h0000, 16'h1000, 16'h8000};
    localparam int          TB_BITS [NR] = '{8, 4, 12};
    localparam int          TB_WAIT [NR] = '{0, 2, 5};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ini_irdy = 1'b0;
    logic              ini_write = 1'b0;
    logic [15:0]       ini_addr = '0;
    logic [7:0]        ini_wdata = '0;
    logic              ini_trdy;
    logic [7:0]        ini_rdata;
    logic [15:0]       dn_addr;
    logic [7:0]        dn_wdata;
    logic              dn_write;
    logic [NR-1:0]     tgt_irdy;
    logic [NR-1:0]     tgt_trdy;
    logic [NR*8-1:0]   tgt_rdata;
    logic [3:0]        tcnt [NR];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [7:0] last_rd = 8'h00;

    always #5 clk = ~clk;

    cfg_range_bridge #(
        .ADDR_W(16), .DATA_W(8), .N_RANGE(NR),
        .RANGE_BASE({16'h8000, 16'h1000, 16'h0000}),
        .RANGE_BITS({8'd12, 8'd4, 8'd8})
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ini_irdy(ini_irdy), .ini_write(ini_write),
        .ini_addr(ini_addr), .ini_wdata(ini_wdata), .ini_trdy(ini_trdy),
        .ini_rdata(ini_rdata), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_write(dn_write), .tgt_irdy(tgt_irdy), .tgt_trdy(tgt_trdy),
        .tgt_rdata(tgt_rdata)
    );

    // Region models: ready after TB_WAIT[i] cycles of request.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (!rst_n || !tgt_irdy[i] || tgt_trdy[i]) tcnt[i] <= '0;
            else tcnt[i] <= tcnt[i] + 4'd1;
        end
    end

    always_comb begin
        for (int i = 0; i < NR; i++) begin
            tgt_trdy[i] = tgt_irdy[i] && (int'(tcnt[i]) >= TB_WAIT[i]);
            tgt_rdata[i*8 +: 8] = region_data(dn_addr, i);
        end
    end

    function automatic logic [7:0] region_data(input logic [15:0] a, input int i);
        return a[7:0] ^ 8'(8'h5A + i * 8'h11);
    endfunction

    function automatic int exp_idx(input logic [15:0] a);
        for (int i = 0; i < NR; i++)
            if ((a >> TB_BITS[i]) == (TB_BASE[i] >> TB_BITS[i])) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic [15:0] a, input logic w, input bit hold_extra);
        int lat = 0;
        int on_cyc = 0;
        logic [NR-1:0] seen = '0;
        bit fld_ok = 1;
        int k = exp_idx(a);
        logic [7:0] wd = a[7:0] ^ a[15:8] ^ 8'hC3;
        logic [7:0] exp_rd;
        @(negedge clk);
        ini_addr = a; ini_write = w; ini_wdata = wd; ini_irdy = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            seen = seen | tgt_irdy;
            if (|tgt_irdy) begin
                on_cyc++;
                if (dn_addr != a || dn_wdata != wd || dn_write != w) fld_ok = 0;
            end
        end while (!ini_trdy && lat < 40);
        // R5 / R6: completion latency
        check(lat == ((k < 0) ? 2 : 2 + TB_WAIT[k]), (k < 0) ? "R6 latency" : "R5 latency",
              lat, (k < 0) ? 2 : 2 + TB_WAIT[k]);
        // R3 / R6: which region saw the request
        check(seen == ((k < 0) ? NR'(0) : NR'(1 << k)), (k < 0) ? "R6 no target" : "R3 target",
              int'(seen), (k < 0) ? 0 : (1 << k));
        // R4: request length
        check(on_cyc == ((k < 0) ? 0 : TB_WAIT[k] + 1), "R4 request length",
              on_cyc, (k < 0) ? 0 : TB_WAIT[k] + 1);
        // R2: captured fields
        check(fld_ok, "R2 fields", int'(dn_addr), int'(a));
        // R7 / R6: read data
        exp_rd = w ? last_rd : ((k < 0) ? 8'h00 : region_data(a, k));
        check(ini_rdata == exp_rd, w ? "R7 write keeps" : "R7 read data",
              int'(ini_rdata), int'(exp_rd));
        last_rd = exp_rd;
        if (hold_extra) begin
            @(negedge clk);
            // R8: no reissue, R5: pulse ended
            check(tgt_irdy == '0 && !ini_trdy, "R8 no reissue",
                  int'({ini_trdy, tgt_irdy}), 0);
        end
        ini_irdy = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] edges [8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ini_trdy == 1'b0 && tgt_irdy == '0, "R1 handshake outputs",
              int'({ini_trdy, tgt_irdy}), 0);
        check(dn_addr == '0 && dn_wdata == '0 && !dn_write, "R1 fields",
              int'(dn_addr), 0);
        check(ini_rdata == '0, "R1 read data", int'(ini_rdata), 0);

        // Window edges of every region, read and write.
        for (int i = 0; i < NR; i++) begin
            logic [15:0] sz = 16'(1 << TB_BITS[i]);
            do_access(TB_BASE[i], 1'b0, 1'b0);
            do_access(TB_BASE[i] + sz - 16'd1, 1'b0, 1'b0);
            do_access(TB_BASE[i] + sz, 1'b0, 1'b0);
            do_access(TB_BASE[i] - 16'd1, 1'b1, 1'b0);
            do_access(TB_BASE[i] + 16'd1, 1'b1, 1'b1);
        end

        // Sweep of every upper address byte.
        for (int h = 0; h < 256; h++) begin
            logic [15:0] a = {8'(h), 8'(h * 37)};
            do_access(a, (h % 3) == 1, (h % 7) == 0);
        end

        // Mid-sequence reset.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(ini_rdata == '0 && dn_addr == '0, "R1 second reset", int'(ini_rdata), 0);
        last_rd = 8'h00;
        do_access(16'h8ABC, 1'b0, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule